// File: doc/BRIEF.md
# Byte-level sequencer with one-shot strong pullup for a 1-Wire master

This block turns byte commands into eight consecutive bit-slot requests for a lower bit-slot engine on a 1-Wire bus. It has three kinds of byte operation. A write sends the eight data bits. A read releases the bus in every slot and collects the sampled levels. A touch sends each data bit and returns the levels sampled in those slots. The requester starts a byte on an idle block and waits for a one-cycle done strobe. Read and touch results are then available on a data output. A multi-byte transfer is a series of single-byte commands.

The block also serves a one-shot strong-pullup request. Software registers a duration in milliseconds at any time, and a duration of zero removes the request. The next write byte services the request. If the strong-pullup hardware is enabled, the pullup output is driven from the last bit slot of that byte and held for the requested time after the slot completes. If it is disabled, the block waits for the same time with the pullup output low. Either way the request is then consumed. A millisecond prescaler, set by a parameter, measures the time in clock cycles.

Top module: `ow_byte_xfer`

## Requirements
- R1: A write byte (op code 0) issues eight slots, and slot i drives bit i of the command byte, least significant bit first.
- R2: A read byte (op code 1) drives 1 in every slot, and rdata_o bit i holds the level sampled in slot i.
- R3: A touch byte (op code 2, and the reserved code 3) drives bit i of the command byte in slot i, and rdata_o bit i holds the level sampled in slot i.
- R4: A command is taken only while busy_o is low, and cmd_valid_i has no effect while a byte is in progress. done_o is a one-cycle pulse in the cycle after the last slot completes when no hold is due, and busy_o falls after it.
- R5: A stored duration of zero means no pullup. A request with duration zero cancels an earlier nonzero request, so the next write finishes without a hold and strong_pu_o stays low.
- R6: With a nonzero request pending and pu_enable_i high (sampled when slot 6 completes), strong_pu_o is high in the cycle the eighth slot of a write byte is requested. It is low during the first seven slots.
- R7: In the case of R6, strong_pu_o stays high for exactly ms × CLK_PER_MS cycles after the eighth slot completes. It falls in the cycle done_o is high.
- R8: With a nonzero request pending and pu_enable_i low, a write byte waits the same ms × CLK_PER_MS cycles before done_o, and strong_pu_o stays low.
- R9: A request is consumed by the first write byte after it. Read and touch bytes neither use nor consume it.
- R10: A request given in the same cycle that a write byte consumes the pending one is kept as the new pending request.
- R11: After reset, busy_o, done_o, slot_req_o and strong_pu_o are low, rdata_o is zero, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Start a byte (taken while idle) |
| cmd_op_i | input | 2 | 0 write, 1 read, 2 or 3 touch |
| cmd_byte_i | input | DATA_W | Byte to send |
| busy_o | output | 1 | Byte in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | DATA_W | Sampled bits of the last read or touch |
| pu_req_i | input | 1 | Register a pullup duration |
| pu_ms_i | input | MS_W | Duration in milliseconds, zero cancels |
| pu_enable_i | input | 1 | Strong-pullup hardware present and enabled |
| strong_pu_o | output | 1 | Strong pullup drive |
| slot_req_o | output | 1 | One-cycle request for one bit slot |
| slot_bit_o | output | 1 | Bit to drive in the requested slot |
| slot_done_i | input | 1 | Slot engine finished the slot |
| slot_level_i | input | 1 | Level sampled in that slot, valid with slot_done_i |

## Verification
Two functions can meet in one cycle: a write byte consuming the pending pullup request, and software registering a new one. The bench raises pu_req_i in the same cycle that it completes slot 6 of a write, which is the cycle the pullup is armed. It then checks that the current byte holds for the old duration and that the following write holds for the new one. The same stimulus is applied during read and touch bytes, where it must simply replace the pending duration.

// File: rtl/ow_byte_pkg.sv
package ow_byte_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_TOUCH = 2'd2,
    OP_RSVD  = 2'd3
  } ow_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_HOLD,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/ow_pullup_ctl.sv
module ow_pullup_ctl #(
  parameter int MS_W       = 8,
  parameter int CLK_PER_MS = 100000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [MS_W-1:0] ms_i,
  input  logic            enable_i,
  input  logic            arm_i,
  input  logic            hold_i,
  output logic            active_o,
  output logic            drive_o,
  output logic            expire_o
);
  localparam int PRE_W = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic [MS_W-1:0]  req_ms_q, ms_cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             active_q, use_pu_q;
  logic             pend, wrap;

  assign pend     = (req_ms_q != '0);
  assign wrap     = hold_i && (pre_q == PRE_LAST);
  assign expire_o = wrap && (ms_cnt_q == MS_W'(1));
  assign active_o = active_q;
  assign drive_o  = active_q && use_pu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_ms_q <= '0;
      ms_cnt_q <= '0;
      pre_q    <= '0;
      active_q <= 1'b0;
      use_pu_q <= 1'b0;
    end else begin
      if (arm_i && pend) begin
        // service point: latch duration, consume request (new request wins)
        ms_cnt_q <= req_ms_q;
        active_q <= 1'b1;
        use_pu_q <= enable_i;
        req_ms_q <= req_i ? ms_i : '0;
      end else if (req_i) begin
        req_ms_q <= ms_i;
      end
      if (hold_i) begin
        if (wrap) begin
          pre_q    <= '0;
          ms_cnt_q <= ms_cnt_q - MS_W'(1);
          if (ms_cnt_q == MS_W'(1)) active_q <= 1'b0;
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end else begin
        pre_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ow_byte_seq.sv
module ow_byte_seq
  import ow_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_byte_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              slot_req_o,
  output logic              slot_bit_o,
  input  logic              slot_done_i,
  input  logic              slot_level_i,
  input  logic              pu_active_i,
  input  logic              pu_expire_i,
  output logic              arm_o,
  output logic              hold_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_ARM  = IDX_W'(DATA_W - 2);

  seq_st_e           st_q;
  ow_op_e            op_q;
  logic [DATA_W-1:0] sh_q, sh_next, rdata_q;
  logic [IDX_W-1:0]  idx_q;
  logic              is_write, slot_end;

  assign is_write   = (op_q == OP_WRITE);
  assign slot_end   = (st_q == ST_WAIT) && slot_done_i;
  assign sh_next    = {slot_level_i, sh_q[DATA_W-1:1]};
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
  assign slot_req_o = (st_q == ST_ISSUE);
  assign slot_bit_o = (op_q == OP_READ) ? 1'b1 : sh_q[0];
  assign arm_o      = slot_end && is_write && (idx_q == IDX_ARM);
  assign hold_o     = (st_q == ST_HOLD);
  assign rdata_o    = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_WRITE;
      sh_q    <= '0;
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          op_q  <= ow_op_e'(cmd_op_i);
          sh_q  <= cmd_byte_i;
          idx_q <= '0;
          st_q  <= ST_ISSUE;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (slot_done_i) begin
          sh_q <= sh_next;
          if (idx_q == IDX_LAST) begin
            if (!is_write) rdata_q <= sh_next;
            st_q <= (is_write && pu_active_i) ? ST_HOLD : ST_DONE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            st_q  <= ST_ISSUE;
          end
        end
        ST_HOLD: if (pu_expire_i) st_q <= ST_DONE;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_byte_xfer.sv
module ow_byte_xfer #(
  parameter int DATA_W     = 8,
  parameter int MS_W       = 8,
  parameter int CLK_PER_MS = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_byte_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pu_req_i,
  input  logic [MS_W-1:0]   pu_ms_i,
  input  logic              pu_enable_i,
  output logic              strong_pu_o,
  output logic              slot_req_o,
  output logic              slot_bit_o,
  input  logic              slot_done_i,
  input  logic              slot_level_i
);
  logic arm, hold, pu_active, pu_expire;

  ow_byte_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .cmd_byte_i   (cmd_byte_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .rdata_o      (rdata_o),
    .slot_req_o   (slot_req_o),
    .slot_bit_o   (slot_bit_o),
    .slot_done_i  (slot_done_i),
    .slot_level_i (slot_level_i),
    .pu_active_i  (pu_active),
    .pu_expire_i  (pu_expire),
    .arm_o        (arm),
    .hold_o       (hold)
  );

  ow_pullup_ctl #(.MS_W(MS_W), .CLK_PER_MS(CLK_PER_MS)) u_pu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (pu_req_i),
    .ms_i     (pu_ms_i),
    .enable_i (pu_enable_i),
    .arm_i    (arm),
    .hold_i   (hold),
    .active_o (pu_active),
    .drive_o  (strong_pu_o),
    .expire_o (pu_expire)
  );
endmodule

// File: rtl/ow_byte_xfer_chk.sv
module ow_byte_xfer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic strong_pu_o,
  input logic slot_req_o
);
  p_slot_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |=> !slot_req_o);
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
  p_pu_in_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strong_pu_o |-> busy_o);
  p_pu_rise_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strong_pu_o) |-> slot_req_o);
  p_pu_fall_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strong_pu_o) |-> done_o);
  p_pu_off_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !strong_pu_o);
endmodule

bind ow_byte_xfer ow_byte_xfer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .strong_pu_o (strong_pu_o),
  .slot_req_o  (slot_req_o)
);

// File: tb/ow_byte_xfer_test.sv
module ow_byte_xfer_test;
  localparam int DW  = 8;
  localparam int MW  = 8;
  localparam int CPM = 5;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [1:0]    cmd_op_i = '0;
  logic [DW-1:0] cmd_byte_i = '0;
  logic          busy_o, done_o, strong_pu_o, slot_req_o, slot_bit_o;
  logic [DW-1:0] rdata_o;
  logic          pu_req_i = 1'b0, pu_enable_i = 1'b0;
  logic [MW-1:0] pu_ms_i = '0;
  logic          slot_done_i = 1'b0, slot_level_i = 1'b0;

  int errors = 0, checks = 0;
  int exp_pend = 0;

  ow_byte_xfer #(.DATA_W(DW), .MS_W(MW), .CLK_PER_MS(CPM)) uut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_req(input int ms);
    @(negedge clk_i);
    pu_req_i = 1'b1; pu_ms_i = MW'(ms);
    @(negedge clk_i);
    pu_req_i = 1'b0;
    exp_pend = ms;
  endtask

  // op: 0 write, 1 read, 2 touch; arm_ms >= 0 gives a request at slot 6 completion
  task automatic run_byte(input int op, input logic [DW-1:0] data, input logic [DW-1:0] lv,
                          input bit en, input int arm_ms, input bit noise);
    bit serv, exp_pu, prev_pu, any_pu;
    int hold, gap, to;
    serv   = (op == 0) && (exp_pend != 0);
    exp_pu = serv && en;
    hold   = serv ? exp_pend * CPM : 0;
    any_pu = 1'b0;
    pu_enable_i = en;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 2'(op); cmd_byte_i = data;
    @(negedge clk_i);
    if (!noise) cmd_valid_i = 1'b0;
    else begin cmd_op_i = 2'($urandom % 3); cmd_byte_i = ~data; end
    for (int i = 0; i < DW; i++) begin
      to = 0;
      while (!slot_req_o && to < 50) begin
        if (strong_pu_o) any_pu = 1'b1;
        @(negedge clk_i); to++;
      end
      chk(slot_req_o, "R4 slot request", int'(slot_req_o), 1);
      if (op == 1) chk(slot_bit_o == 1'b1, "R2 read slot drives 1", int'(slot_bit_o), 1);
      else if (op == 2) chk(slot_bit_o == data[i], "R3 touch slot bit", int'(slot_bit_o), int'(data[i]));
      else chk(slot_bit_o == data[i], "R1 write slot bit", int'(slot_bit_o), int'(data[i]));
      if (i == DW - 1) chk(strong_pu_o == exp_pu, "R6 pullup at last slot", int'(strong_pu_o), int'(exp_pu));
      else chk(!strong_pu_o, "R6 pullup low before last slot", int'(strong_pu_o), 0);
      if (strong_pu_o) any_pu = 1'b1;
      repeat (1 + ($urandom % 3)) begin
        @(negedge clk_i);
        if (strong_pu_o) any_pu = 1'b1;
      end
      slot_done_i = 1'b1; slot_level_i = lv[i];
      if (i == DW - 2 && arm_ms >= 0) begin pu_req_i = 1'b1; pu_ms_i = MW'(arm_ms); end
      if (i == DW - 1) begin cmd_valid_i = 1'b0; prev_pu = strong_pu_o; end
      @(negedge clk_i);
      slot_done_i = 1'b0; pu_req_i = 1'b0;
    end
    gap = 1;
    while (!done_o && gap < 5000) begin
      prev_pu = strong_pu_o;
      if (strong_pu_o) any_pu = 1'b1;
      @(negedge clk_i); gap++;
    end
    chk(done_o, "R4 done strobe", int'(done_o), 1);
    if (op == 0 && serv && !en) chk(gap == hold + 1, "R8 fallback wait", gap, hold + 1);
    else if (op == 0 && serv) chk(gap == hold + 1, "R7 hold length", gap, hold + 1);
    else chk(gap == 1, "R5 R9 no hold", gap, 1);
    chk(prev_pu == exp_pu, "R7 pullup held to end", int'(prev_pu), int'(exp_pu));
    chk(!strong_pu_o, "R7 pullup off at done", int'(strong_pu_o), 0);
    chk(any_pu == exp_pu, "R8 pullup drive seen", int'(any_pu), int'(exp_pu));
    if (op != 0) chk(rdata_o == lv, "R2 R3 sampled byte", int'(rdata_o), int'(lv));
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R4 single done then idle", int'({done_o, busy_o}), 0);
    if (arm_ms >= 0) exp_pend = arm_ms;
    else if (serv) exp_pend = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b17));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk(!busy_o && !done_o && !slot_req_o && !strong_pu_o, "R11 reset outputs",
        int'({busy_o, done_o, slot_req_o, strong_pu_o}), 0);
    chk(rdata_o == '0, "R11 reset rdata", int'(rdata_o), 0);
    run_byte(0, 8'hA5, 8'h00, 1'b1, -1, 1'b0);   // R1, R11 no pending
    run_byte(1, 8'h00, 8'h3C, 1'b1, -1, 1'b0);   // R2
    run_byte(2, 8'h96, 8'h5A, 1'b1, -1, 1'b0);   // R3
    set_req(2);
    run_byte(0, 8'h81, 8'h00, 1'b1, -1, 1'b0);   // R6 R7
    run_byte(0, 8'h7E, 8'h00, 1'b1, -1, 1'b0);   // R9 consumed
    set_req(3);
    run_byte(0, 8'h42, 8'h00, 1'b0, -1, 1'b0);   // R8
    set_req(2); set_req(0);
    run_byte(0, 8'hFF, 8'h00, 1'b1, -1, 1'b0);   // R5 cancel
    set_req(1);
    run_byte(2, 8'h33, 8'hC3, 1'b1, -1, 1'b0);   // R9 touch leaves request
    run_byte(1, 8'h00, 8'h0F, 1'b1, -1, 1'b0);   // R9 read leaves request
    run_byte(0, 8'h18, 8'h00, 1'b1, -1, 1'b0);   // R9 write uses it
    set_req(2);
    run_byte(0, 8'h01, 8'h00, 1'b1, 3, 1'b0);    // R10 request in arming cycle
    run_byte(0, 8'h80, 8'h00, 1'b1, -1, 1'b0);   // R10 new request held 3 ms
    run_byte(0, 8'hC9, 8'h00, 1'b1, -1, 1'b1);   // R4 start ignored while busy
    for (int n = 0; n < 60; n++) begin
      if ($urandom % 4 == 0) set_req(int'($urandom % 4));
      run_byte(int'($urandom % 3), DW'($urandom), DW'($urandom), 1'($urandom),
               ($urandom % 5 == 0) ? int'($urandom % 3) : -1, 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule